// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a key matrix of six drive lines by five sense lines, one clock period per unit of the scan timebase. While idle it holds the drive lines at a mode-dependent rest pattern and watches the synchronised sense lines. When a key shows up, it drives each row alone in turn, twice over. It accepts the result only when both passes agree. If the passes disagree and the second pass still saw a key, it starts a fresh pair of passes. If the second pass saw nothing, it returns to idle.

Agreed data is frozen in a key buffer and the block pulls its active-low, open-drain request low. Scanning stops until the host finishes a read. The host selects a read by raising chip enable while the shift clock is low. It then clocks out a 32-bit frame on the same pin. The host may also run a write cycle (chip enable raised with the shift clock high) while a request is pending. The pin is then released for that cycle and the request stays pending.

Top module: `keyscan_top`

## Requirements
- R1: After reset the data-out pin is high, every drive line is low and the key buffer holds zeros. Key presses start no scan until the first chip-enable cycle has ended.
- R2: While idle or holding a request, `driveOut[r]` is high exactly for the enabled rows (see R7). With all rows enabled the rest pattern is 6'b111111. In power-save 1 it is 6'b100000, and in power-save 2 it is 6'b110000.
- R3: A scan drives one enabled row at a time for SLOT_CYCLES cycles each, in the order row 0 to row 5, and no row outside the scan. With SLOT_CYCLES = 48, when the first two passes agree, `soN` goes low 577 cycles after the first cycle of the scan.
- R4: If the two passes differ and the second pass holds a key, two new passes follow at once, so the request comes 1154 cycles after the first scan start. If the second pass holds no key, the block returns to idle with no request.
- R5: While a request is pending no scan runs. The drive lines keep the rest pattern, and later key changes do not alter the data that is read out.
- R6: A read is selected when chip enable rises with the shift clock low. The frame on `soN` is bit 0 (high, don't-care), then KD1 to KD30, then the power-save flag. Each shift-clock fall moves to the next bit. KD number = 5*row + sense column + 1.
- R7: `keySel` 2'b00 enables all rows, 2'b01 disables row 0, and 2'b1x disables rows 0 and 1. `psMode` 2'b01 enables only row 5, 2'b10 only rows 4 and 5, and 2'b00 or 2'b11 all rows. A row is enabled only if both selections enable it. A disabled row is never driven and reads as 0, and its keys start no scan.
- R8: The last frame bit is 1 when `psMode` is not 2'b00 and 0 otherwise.
- R9: Chip enable falling at the end of a read releases a pending request, and `soN` goes high. A write cycle holds `soN` high while chip enable is high and leaves the request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan timebase, one cycle per period |
| rstN | input | 1 | Active-low reset |
| senseIn | input | 5 | Sense lines, high for a closed key on a driven row |
| keySel | input | 2 | Key-count selection |
| psMode | input | 2 | Power-save mode |
| csIn | input | 1 | Chip enable from the host |
| sclkIn | input | 1 | Shift clock from the host |
| driveOut | output | 6 | Drive lines, one per row |
| soN | output | 1 | Open-drain request and serial data out (1 = released) |

## Verification
A scan is counted from the first sampled cycle whose drive lines leave the rest pattern. The request must then appear exactly 577 cycles later, or 1154 after a rejected pair. The bench measures that gap from the ports instead of from the press, so synchroniser delay does not enter the count. Chip-enable and shift-clock changes take effect on the next edge. The bench waits two whole cycles after each such change before it samples `soN`. Cases that must raise no request are watched for longer than a full pair of passes.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int KS_ROWS  = 6;
  localparam int KS_COLS  = 5;
  localparam int KS_KEYS  = KS_ROWS * KS_COLS;
  localparam int KS_FRAME = KS_KEYS + 2;
  localparam int ROW_W    = $clog2(KS_ROWS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_CMP,
    ST_HOLD
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             sampleEn;
    logic             passSel;
    logic [ROW_W-1:0] rowIdx;
    logic             latchKeys;
    logic             loadFrame;
    logic             shiftFrame;
  } scanStrobe_t;
endpackage

// File: rtl/keyscan_datapath.sv
module keyscan_datapath
  import keyscan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [KS_COLS-1:0] senseIn,
  input  logic [KS_ROWS-1:0] rowEn,
  input  logic               psfBit,
  input  scanStrobe_t        strb,
  output logic               match,
  output logic               scanNonZero,
  output logic               senseAny,
  output logic [KS_KEYS-1:0] keyData,
  output logic               frameBit
);
  logic [KS_COLS-1:0]  syncQ [SYNC_STAGES];
  logic [KS_KEYS-1:0]  passA;
  logic [KS_KEYS-1:0]  passB;
  logic [KS_FRAME-1:0] frameQ;
  logic [KS_COLS-1:0]  senseS;

  assign senseS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= senseIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  // one row slice per drive line, masked by the row enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passA <= '0;
      passB <= '0;
    end else if (strb.sampleEn) begin
      for (int r = 0; r < KS_ROWS; r++) begin
        if (strb.rowIdx == ROW_W'(r)) begin
          if (strb.passSel) passB[r*KS_COLS +: KS_COLS] <= senseS & {KS_COLS{rowEn[r]}};
          else              passA[r*KS_COLS +: KS_COLS] <= senseS & {KS_COLS{rowEn[r]}};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyData <= '0;
    else if (strb.latchKeys) keyData <= passB;
  end

  // frame: bit 0 don't-care, keys, flag last; shifted out LSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameQ <= '1;
    else if (strb.loadFrame) frameQ <= {psfBit, keyData, 1'b1};
    else if (strb.shiftFrame) frameQ <= {1'b1, frameQ[KS_FRAME-1:1]};
  end

  assign match       = (passA == passB);
  assign scanNonZero = |passB;
  assign senseAny    = |senseS;
  assign frameBit    = frameQ[0];
endmodule

// File: rtl/keyscan_control.sv
module keyscan_control
  import keyscan_pkg::*;
#(
  parameter int SLOT_CYCLES = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         keySel,
  input  logic [1:0]         psMode,
  input  logic               csIn,
  input  logic               sclkIn,
  input  logic               match,
  input  logic               scanNonZero,
  input  logic               senseAny,
  input  logic               frameBit,
  output scanStrobe_t        strb,
  output logic [KS_ROWS-1:0] rowEn,
  output logic [KS_ROWS-1:0] driveOut,
  output logic               soN,
  output logic               pending,
  output logic               armed,
  output logic               psfBit
);
  localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(KS_ROWS - 1);

  scanState_t        state;
  logic [SLOT_W-1:0] slotCnt;
  logic [ROW_W-1:0]  rowIdx;
  logic              passQ;
  logic              csD;
  logic              sclkD;
  logic              readMode;
  logic              csRise;
  logic              csFall;
  logic              slotEnd;
  logic [ROW_W:0]    keySkip;
  logic [ROW_W:0]    psSkip;

  assign csRise  = csIn & ~csD;
  assign csFall  = ~csIn & csD;
  assign slotEnd = (state == ST_SCAN) && (slotCnt == SLOT_LAST);

  // rows below the skip counts are disabled
  always_comb begin
    case (keySel)
      2'b00:   keySkip = '0;
      2'b01:   keySkip = (ROW_W+1)'(1);
      default: keySkip = (ROW_W+1)'(2);
    endcase
    case (psMode)
      2'b01:   psSkip = (ROW_W+1)'(KS_ROWS - 1);
      2'b10:   psSkip = (ROW_W+1)'(KS_ROWS - 2);
      default: psSkip = '0;
    endcase
  end

  for (genvar r = 0; r < KS_ROWS; r++) begin : g_row
    assign rowEn[r]    = ((ROW_W+1)'(r) >= keySkip) && ((ROW_W+1)'(r) >= psSkip);
    assign driveOut[r] = rowEn[r] & ((state == ST_SCAN) ? (rowIdx == ROW_W'(r)) : armed);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slotCnt  <= '0;
      rowIdx   <= '0;
      passQ    <= 1'b0;
      csD      <= 1'b0;
      sclkD    <= 1'b0;
      readMode <= 1'b0;
      armed    <= 1'b0;
    end else begin
      csD   <= csIn;
      sclkD <= sclkIn;
      if (csRise) readMode <= ~sclkIn;
      if (csFall) armed <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (armed && senseAny) begin
            state   <= ST_SCAN;
            slotCnt <= '0;
            rowIdx  <= '0;
            passQ   <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (slotCnt == SLOT_LAST) begin
            slotCnt <= '0;
            if (rowIdx == ROW_LAST) begin
              rowIdx <= '0;
              passQ  <= ~passQ;
              if (passQ) state <= ST_CMP;
            end else begin
              rowIdx <= rowIdx + 1'b1;
            end
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        ST_CMP: begin
          if (!scanNonZero) state <= ST_IDLE;
          else if (match)   state <= ST_HOLD;
          else              state <= ST_SCAN;
        end
        ST_HOLD: begin
          if (csFall && readMode) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pending = (state == ST_HOLD);
  assign psfBit  = |psMode;

  always_comb begin
    strb.sampleEn   = slotEnd;
    strb.passSel    = passQ;
    strb.rowIdx     = rowIdx;
    strb.latchKeys  = (state == ST_CMP) && match && scanNonZero;
    strb.loadFrame  = csRise && !sclkIn;
    strb.shiftFrame = csD && !csRise && readMode && sclkD && !sclkIn;
  end

  assign soN = csD ? (readMode ? frameBit : 1'b1) : ~pending;
endmodule

// File: rtl/keyscan_top.sv
module keyscan_top
  import keyscan_pkg::*;
#(
  parameter int SLOT_CYCLES = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [KS_COLS-1:0] senseIn,
  input  logic [1:0]         keySel,
  input  logic [1:0]         psMode,
  input  logic               csIn,
  input  logic               sclkIn,
  output logic [KS_ROWS-1:0] driveOut,
  output logic               soN
);
  scanStrobe_t        strb;
  logic [KS_ROWS-1:0] rowEn;
  logic               match;
  logic               scanNonZero;
  logic               senseAny;
  logic [KS_KEYS-1:0] keyData;
  logic               frameBit;
  logic               pending;
  logic               armed;
  logic               psfBit;

  keyscan_control #(.SLOT_CYCLES(SLOT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .keySel(keySel), .psMode(psMode),
    .csIn(csIn), .sclkIn(sclkIn), .match(match), .scanNonZero(scanNonZero),
    .senseAny(senseAny), .frameBit(frameBit), .strb(strb), .rowEn(rowEn),
    .driveOut(driveOut), .soN(soN), .pending(pending), .armed(armed),
    .psfBit(psfBit)
  );

  keyscan_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .senseIn(senseIn), .rowEn(rowEn),
    .psfBit(psfBit), .strb(strb), .match(match), .scanNonZero(scanNonZero),
    .senseAny(senseAny), .keyData(keyData), .frameBit(frameBit)
  );
endmodule

// File: rtl/keyscan_checker.sv
module keyscan_checker
  import keyscan_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               csIn,
  input logic               sclkIn,
  input logic [1:0]         keySel,
  input logic [1:0]         psMode,
  input logic [KS_ROWS-1:0] driveOut,
  input logic               soN,
  input logic               pending,
  input logic               armed,
  input scanStrobe_t        strb,
  input logic [KS_KEYS-1:0] keyData
);
  // R1
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!pending && driveOut == '0));

  // R3
  scan_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleEn |-> $onehot0(driveOut));

  // R4
  grant_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> (keyData != '0));

  // R5
  hold_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> ($stable(driveOut) || !$stable(psMode) || !$stable(keySel)));

  // R6
  read_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csIn) && !sclkIn) |=> soN);

  // R9
  write_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(csIn) && sclkIn) |=> soN);
endmodule

bind keyscan_top keyscan_checker u_chk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .keySel(keySel),
  .psMode(psMode), .driveOut(driveOut), .soN(soN), .pending(pending),
  .armed(armed), .strb(strb), .keyData(keyData)
);

// File: tb/tb_keyscan_top.sv
module tb_keyscan_top;
  import keyscan_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 48;
  localparam int SCAN_LAT   = 2 * KS_ROWS * SLOT + 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [KS_COLS-1:0] senseIn;
  logic [1:0]         keySel = 2'b00;
  logic [1:0]         psMode = 2'b00;
  logic               csIn = 1'b0;
  logic               sclkIn = 1'b0;
  logic [KS_ROWS-1:0] driveOut;
  logic               soN;
  logic [KS_KEYS-1:0] pressed = '0;
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  keyscan_top #(.SLOT_CYCLES(SLOT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .senseIn(senseIn), .keySel(keySel),
    .psMode(psMode), .csIn(csIn), .sclkIn(sclkIn), .driveOut(driveOut),
    .soN(soN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // key matrix model: a closed key passes its driven row to its column
  always_comb begin
    senseIn = '0;
    for (int r = 0; r < KS_ROWS; r++)
      for (int c = 0; c < KS_COLS; c++)
        if (driveOut[r] && pressed[r*KS_COLS + c]) senseIn[c] = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [KS_ROWS-1:0] expRowEn(input logic [1:0] k, input logic [1:0] p);
    int ks;
    int ps;
    logic [KS_ROWS-1:0] en;
    ks = (k == 2'b00) ? 0 : (k == 2'b01) ? 1 : 2;
    ps = (p == 2'b01) ? KS_ROWS - 1 : (p == 2'b10) ? KS_ROWS - 2 : 0;
    for (int r = 0; r < KS_ROWS; r++) en[r] = (r >= ks) && (r >= ps);
    return en;
  endfunction

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readFrame(output logic [KS_FRAME-1:0] fr);
    sclkIn = 1'b0;
    csIn = 1'b1;
    waitCycles(2);
    fr[0] = soN;
    for (int i = 1; i < KS_FRAME; i++) begin
      sclkIn = 1'b1;
      waitCycles(2);
      sclkIn = 1'b0;
      waitCycles(2);
      fr[i] = soN;
    end
  endtask

  task automatic endRead();
    csIn = 1'b0;
    waitCycles(3);
  endtask

  task automatic waitRequest(input logic [KS_ROWS-1:0] idle, input int limit,
                             output int lat, output bit got);
    int t0;
    t0 = -1;
    got = 1'b0;
    lat = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (t0 < 0 && driveOut != idle) t0 = cyc;
      if (t0 >= 0 && !soN) begin
        lat = cyc - t0;
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic runKey(input int k);
    logic [KS_ROWS-1:0]  en;
    logic [KS_FRAME-1:0] fr;
    logic [KS_KEYS-1:0]  expV;
    int lat;
    bit got;
    en = expRowEn(keySel, psMode);
    pressed = '0;
    pressed[k] = 1'b1;
    if (en[k / KS_COLS]) begin
      waitRequest(en, 3000, lat, got);
      // R3: request timing after an agreeing pair
      check(got && lat == SCAN_LAT, "R3 latency", lat, SCAN_LAT);
      readFrame(fr);
      expV = '0;
      expV[k] = 1'b1;
      // R6: frame order and key numbering
      check(fr[KS_KEYS:1] == expV, "R6 frame keys", fr[KS_KEYS:1], expV);
      // R8: trailing power-save flag
      check(fr[KS_FRAME-1] == (psMode != 2'b00), "R8 flag", fr[KS_FRAME-1], psMode != 2'b00);
      pressed = '0;
      waitCycles(4);
      endRead();
      // R9: released after the read
      check(soN == 1'b1, "R9 release", soN, 1);
    end else begin
      waitRequest(en, 700, lat, got);
      // R7: disabled row neither scans nor requests
      check(!got && driveOut == en, "R7 masked key", {got, driveOut}, {1'b0, en});
      pressed = '0;
      waitCycles(5);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [KS_FRAME-1:0] fr;
    logic [KS_KEYS-1:0]  expV;
    logic [KS_ROWS-1:0]  held;
    int t0;
    int lat;
    bit got;
    bit ok;
    bit sawLow;
    logic [1:0] kList [5];
    logic [1:0] pList [5];
    kList = '{2'b01, 2'b10, 2'b00, 2'b00, 2'b00};
    pList = '{2'b00, 2'b00, 2'b01, 2'b10, 2'b11};

    waitCycles(4);
    // R1: reset state
    check(soN == 1'b1, "R1 reset soN", soN, 1);
    check(driveOut == '0, "R1 reset drive", driveOut, 0);
    rstN = 1'b1;
    waitCycles(2);
    pressed[0] = 1'b1;
    waitCycles(700);
    // R1: no scan before the first chip-enable cycle
    check(soN == 1'b1 && driveOut == '0, "R1 disarmed", {soN, driveOut}, 7'h40);
    pressed = '0;
    waitCycles(4);
    readFrame(fr);
    // R1: key buffer cleared by reset
    check(fr[KS_KEYS:1] == '0, "R1 buffer zero", fr[KS_KEYS:1], 0);
    endRead();
    // R2: rest pattern, all rows enabled
    check(driveOut == 6'h3f, "R2 idle normal", driveOut, 6'h3f);

    for (int k = 0; k < KS_KEYS; k++) runKey(k);

    // R4: disagreeing pair with a key still held rescans
    pressed = '0;
    pressed[6] = 1'b1;
    t0 = -1;
    for (int i = 0; i < 100 && t0 < 0; i++) begin
      @(negedge clk);
      if (driveOut != 6'h3f) t0 = cyc;
    end
    waitCycles(300);
    pressed[27] = 1'b1;
    lat = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!soN) begin
        lat = cyc - t0;
        break;
      end
    end
    check(lat == 2 * SCAN_LAT, "R4 rescan latency", lat, 2 * SCAN_LAT);
    readFrame(fr);
    expV = '0;
    expV[6] = 1'b1;
    expV[27] = 1'b1;
    check(fr[KS_KEYS:1] == expV, "R4 rescan data", fr[KS_KEYS:1], expV);
    pressed = '0;
    waitCycles(4);
    endRead();

    // R4: empty second pass gives up with no request
    pressed[6] = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (driveOut != 6'h3f) break;
    end
    waitCycles(200);
    pressed = '0;
    sawLow = 1'b0;
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk);
      if (!soN) sawLow = 1'b1;
    end
    check(!sawLow && driveOut == 6'h3f, "R4 short press", {sawLow, driveOut}, 7'h3f);

    // R5: scanning halts and data freezes while pending
    pressed[11] = 1'b1;
    waitRequest(6'h3f, 3000, lat, got);
    check(got, "R5 request", got, 1);
    pressed[2] = 1'b1;
    held = driveOut;
    ok = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (driveOut != held || soN) ok = 1'b0;
    end
    check(ok && held == 6'h3f, "R5 hold drive", held, 6'h3f);
    // R9: write cycle releases the pin only while chip enable is high
    sclkIn = 1'b1;
    waitCycles(1);
    csIn = 1'b1;
    waitCycles(2);
    check(soN == 1'b1, "R9 write high", soN, 1);
    sclkIn = 1'b0;
    waitCycles(1);
    csIn = 1'b0;
    waitCycles(3);
    check(soN == 1'b0, "R9 still pending", soN, 0);
    readFrame(fr);
    expV = '0;
    expV[11] = 1'b1;
    check(fr[KS_KEYS:1] == expV, "R5 frozen data", fr[KS_KEYS:1], expV);
    pressed = '0;
    waitCycles(4);
    endRead();
    check(soN == 1'b1, "R9 read release", soN, 1);

    // R7 sweep over the other key-count and power-save settings
    for (int m = 0; m < 5; m++) begin
      keySel = kList[m];
      psMode = pList[m];
      waitCycles(3);
      // R2: rest pattern follows the enabled rows
      check(driveOut == expRowEn(keySel, psMode), "R2 idle pattern", driveOut,
            expRowEn(keySel, psMode));
      for (int r = 0; r < KS_ROWS; r++) runKey(r * KS_COLS + (r % KS_COLS));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule